// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block shapes the second operand of an integer ALU before the arithmetic or logic stage sees it. It has two sources. The first is a register value that is shifted or rotated by an amount taken either from a 5-bit field in the instruction or from the low byte of another register. The second is an 8-bit constant that is rotated right by an even count. The block also produces the shifter carry-out. Logical instructions use that carry to update the carry flag.

The unit is purely combinational, so there is no state machine. Both outputs follow the inputs within the same cycle. Internally, an amount decoder turns the instruction's amount encoding into an effective shift count plus a flag for the rotate-through-carry case. A shift core applies the count to the register operand, and a separate rotator builds immediate constants. The top level picks either the core result or the rotator result.

Top module: `barrel_operand_shifter`

## Requirements
- R1: The shift kind is coded 00 logical left, 01 logical right, 10 arithmetic right and 11 rotate right. For a count n from 1 to 31 the result is the operand shifted by n. The carry-out is the last bit shifted out: bit 32-n for a left shift and bit n-1 for the right shifts and rotate.
- R2: An instruction amount is a 5-bit unsigned value. A logical left shift with an instruction amount of zero passes the operand unchanged and copies `carry_in` to `carry_out`.
- R3: A logical right or arithmetic right shift with an instruction amount of zero acts as a shift of 32. The logical case gives zero and the arithmetic case gives every bit equal to operand bit 31. In both cases the carry-out is operand bit 31.
- R4: A rotate right with an instruction amount of zero is a 33-bit rotate through the carry. The result is `{carry_in, operand[31:1]}` and the carry-out is operand bit 0.
- R5: When the amount comes from the register byte and that byte is zero, the result equals the operand and `carry_out` equals `carry_in`, whatever the shift kind.
- R6: With a register amount, a logical left or right shift by exactly 32 gives zero, with carry-out operand bit 0 (left) or bit 31 (right). A count above 32 gives zero with carry-out 0.
- R7: With a register amount of 32 or more, an arithmetic right shift fills every bit with operand bit 31, and that bit is also the carry-out.
- R8: A rotate right by a register amount uses the amount modulo 32. A nonzero amount that is a multiple of 32 leaves the value unchanged with carry-out operand bit 31. Any other nonzero amount gives carry-out equal to result bit 31.
- R9: When `use_imm` is 1, the result is `imm_value` zero-extended to 32 bits and rotated right by twice `imm_rot`. In that case the operand, shift kind and amount inputs have no effect.
- R10: For an immediate operand, the carry-out is result bit 31 when `imm_rot` is nonzero, and `carry_in` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_value | input | 32 | Register operand to shift |
| shift_kind | input | 2 | Shift type, coded as in R1 |
| amount_from_reg | input | 1 | 1: take the count from `shamt_reg`, 0: from `shamt_imm` |
| shamt_imm | input | 5 | Instruction-encoded shift amount |
| shamt_reg | input | 8 | Low byte of the amount register |
| use_imm | input | 1 | 1: output the rotated immediate instead of the shifted operand |
| imm_value | input | 8 | 8-bit immediate constant |
| imm_rot | input | 4 | Immediate rotate field (count = 2 x field) |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Shaped second operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The bench builds the block with its default sizes: a 32-bit datapath, an 8-bit register amount, an 8-bit immediate and a 4-bit rotate field. The 8-bit register amount reaches counts of 32, 33, 64, 96 and 255, so the over-range fill, the zero carry and the modulo-32 rotate paths are all driven. The 4-bit rotate field covers all sixteen even immediate rotations, including the zero rotate that passes the carry through. Random vectors are biased toward small and boundary counts, and a reference model that shifts one bit per step checks every vector.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;

endpackage

// File: rtl/bsh_amount_decode.sv
module bsh_amount_decode
    import bsh_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int REGAMT_W = 8,
    parameter int SHIMM_W  = $clog2(DATA_W),
    parameter int AMT_W    = ((REGAMT_W > SHIMM_W) ? REGAMT_W : SHIMM_W + 1) + 1
) (
    input  logic [1:0]          shift_kind,
    input  logic                amount_from_reg,
    input  logic [SHIMM_W-1:0]  shamt_imm,
    input  logic [REGAMT_W-1:0] shamt_reg,
    output logic [AMT_W-1:0]    eff_amt,
    output logic                rrx_mode
);

    shift_kind_e kind;
    assign kind = shift_kind_e'(shift_kind);

    // Turns the instruction-encoded amount into an effective count.
    always_comb begin
        eff_amt  = '0;
        rrx_mode = 1'b0;
        if (amount_from_reg) begin
            eff_amt = AMT_W'(shamt_reg);
        end else if (shamt_imm != '0) begin
            eff_amt = AMT_W'(shamt_imm);
        end else begin
            unique case (kind)
                SK_LSL: eff_amt = '0;
                SK_LSR,
                SK_ASR: eff_amt = AMT_W'(DATA_W);
                SK_ROR: rrx_mode = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/bsh_shift_core.sv
module bsh_shift_core
    import bsh_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int AMT_W   = 9,
    parameter int SHIMM_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] op_value,
    input  logic [1:0]        shift_kind,
    input  logic [AMT_W-1:0]  eff_amt,
    input  logic              rrx_mode,
    input  logic              carry_in,
    output logic [DATA_W-1:0] core_result,
    output logic              core_carry
);

    localparam int ASR_CAP = DATA_W + 1;

    shift_kind_e kind;
    assign kind = shift_kind_e'(shift_kind);

    logic [DATA_W:0]          lsl_wide;
    logic [DATA_W:0]          lsr_wide;
    logic signed [DATA_W:0]   asr_wide;
    logic [AMT_W-1:0]         asr_amt;
    logic [DATA_W-1:0]        ror_val;
    logic [SHIMM_W-1:0]       ror_m;

    always_comb begin
        lsl_wide = {1'b0, op_value} << eff_amt;
        lsr_wide = {op_value, 1'b0} >> eff_amt;
        asr_amt  = (eff_amt > AMT_W'(ASR_CAP)) ? AMT_W'(ASR_CAP) : eff_amt;
        asr_wide = $signed({op_value, 1'b0}) >>> asr_amt;
        ror_m    = eff_amt[SHIMM_W-1:0];
        ror_val  = DATA_W'({op_value, op_value} >> ror_m);
    end

    // Output selection: zero count passes through, otherwise per kind.
    always_comb begin
        core_result = op_value;
        core_carry  = carry_in;
        if (rrx_mode) begin
            core_result = {carry_in, op_value[DATA_W-1:1]};
            core_carry  = op_value[0];
        end else if (eff_amt != '0) begin
            unique case (kind)
                SK_LSL: begin
                    core_result = lsl_wide[DATA_W-1:0];
                    core_carry  = lsl_wide[DATA_W];
                end
                SK_LSR: begin
                    core_result = lsr_wide[DATA_W:1];
                    core_carry  = lsr_wide[0];
                end
                SK_ASR: begin
                    core_result = asr_wide[DATA_W:1];
                    core_carry  = asr_wide[0];
                end
                SK_ROR: begin
                    core_result = ror_val;
                    core_carry  = ror_val[DATA_W-1];
                end
            endcase
        end
    end

endmodule

// File: rtl/bsh_imm_rotate.sv
module bsh_imm_rotate #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [IMM_W-1:0]  imm_value,
    input  logic [ROT_W-1:0]  imm_rot,
    input  logic              carry_in,
    output logic [DATA_W-1:0] imm_result,
    output logic              imm_carry
);

    localparam int ROTC_W = ROT_W + 1;

    logic [ROTC_W-1:0] rot_cnt;
    logic [DATA_W-1:0] imm_ext;

    always_comb begin
        rot_cnt    = {imm_rot, 1'b0};
        imm_ext    = DATA_W'(imm_value);
        imm_result = DATA_W'({imm_ext, imm_ext} >> rot_cnt);
        imm_carry  = (imm_rot != '0) ? imm_result[DATA_W-1] : carry_in;
    end

endmodule

// File: rtl/barrel_operand_shifter.sv
module barrel_operand_shifter
    import bsh_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int REGAMT_W = 8,
    parameter int IMM_W    = 8,
    parameter int ROT_W    = 4
) (
    input  logic [DATA_W-1:0]          op_value,
    input  logic [1:0]                 shift_kind,
    input  logic                       amount_from_reg,
    input  logic [$clog2(DATA_W)-1:0]  shamt_imm,
    input  logic [REGAMT_W-1:0]        shamt_reg,
    input  logic                       use_imm,
    input  logic [IMM_W-1:0]           imm_value,
    input  logic [ROT_W-1:0]           imm_rot,
    input  logic                       carry_in,
    output logic [DATA_W-1:0]          result,
    output logic                       carry_out
);

    localparam int SHIMM_W = $clog2(DATA_W);
    localparam int AMT_W   = ((REGAMT_W > SHIMM_W) ? REGAMT_W : SHIMM_W + 1) + 1;

    logic [AMT_W-1:0]  eff_amt;
    logic              rrx_mode;
    logic [DATA_W-1:0] core_result, imm_result;
    logic              core_carry, imm_carry;

    bsh_amount_decode #(
        .DATA_W(DATA_W), .REGAMT_W(REGAMT_W), .SHIMM_W(SHIMM_W), .AMT_W(AMT_W)
    ) amt_dec_i (
        .shift_kind(shift_kind), .amount_from_reg(amount_from_reg),
        .shamt_imm(shamt_imm), .shamt_reg(shamt_reg),
        .eff_amt(eff_amt), .rrx_mode(rrx_mode)
    );

    bsh_shift_core #(
        .DATA_W(DATA_W), .AMT_W(AMT_W), .SHIMM_W(SHIMM_W)
    ) core_i (
        .op_value(op_value), .shift_kind(shift_kind), .eff_amt(eff_amt),
        .rrx_mode(rrx_mode), .carry_in(carry_in),
        .core_result(core_result), .core_carry(core_carry)
    );

    bsh_imm_rotate #(
        .DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)
    ) imm_i (
        .imm_value(imm_value), .imm_rot(imm_rot), .carry_in(carry_in),
        .imm_result(imm_result), .imm_carry(imm_carry)
    );

    always_comb begin
        result    = use_imm ? imm_result : core_result;
        carry_out = use_imm ? imm_carry  : core_carry;
    end

    // Port-level checks on the combined outputs of the sub-blocks.
    always_comb begin
        if (!use_imm && !amount_from_reg && shamt_imm == '0 && shift_kind == 2'b00)
            assert_lsl_zero_pass_R2: assert (result == op_value && carry_out == carry_in);
        if (!use_imm && !amount_from_reg && shamt_imm == '0 && shift_kind == 2'b11)
            assert_rrx_carry_R4: assert (carry_out == op_value[0] && result[DATA_W-1] == carry_in);
        if (!use_imm && amount_from_reg && shamt_reg == '0)
            assert_reg_zero_hold_R5: assert (result == op_value && carry_out == carry_in);
        if (!use_imm && amount_from_reg && shift_kind == 2'b10 && shamt_reg >= REGAMT_W'(DATA_W))
            assert_asr_fill_R7: assert (($countones(result) == 0 || $countones(result) == DATA_W)
                                        && carry_out == result[0]);
        if (use_imm && imm_rot == '0)
            assert_imm_norot_R10: assert (result == DATA_W'(imm_value) && carry_out == carry_in);
        if (use_imm)
            assert_imm_bits_R9: assert ($countones(result) == $countones(imm_value));
    end

endmodule

// File: tb/barrel_operand_shifter_tb.sv
module barrel_operand_shifter_tb_top;

    logic        clk = 1'b0;
    logic [31:0] op_value;
    logic [1:0]  shift_kind;
    logic        amount_from_reg;
    logic [4:0]  shamt_imm;
    logic [7:0]  shamt_reg;
    logic        use_imm;
    logic [7:0]  imm_value;
    logic [3:0]  imm_rot;
    logic        carry_in;
    logic [31:0] result;
    logic        carry_out;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    barrel_operand_shifter dut_i (
        .op_value(op_value), .shift_kind(shift_kind), .amount_from_reg(amount_from_reg),
        .shamt_imm(shamt_imm), .shamt_reg(shamt_reg), .use_imm(use_imm),
        .imm_value(imm_value), .imm_rot(imm_rot), .carry_in(carry_in),
        .result(result), .carry_out(carry_out)
    );

    // Reference: one bit per step, straight from the requirements.
    function automatic logic [32:0] ref_model(
        input logic [31:0] op, input logic [1:0] kind, input logic from_reg,
        input logic [4:0] s_imm, input logic [7:0] s_reg, input logic imm_sel,
        input logic [7:0] iv, input logic [3:0] ir, input logic cin);
        logic [31:0] v;
        logic c;
        int n;
        v = op;
        c = cin;
        if (imm_sel) begin
            v = {24'd0, iv};
            for (int i = 0; i < 2 * int'(ir); i++) v = {v[0], v[31:1]};
            if (ir != 0) c = v[31];
            return {c, v};
        end
        n = from_reg ? int'(s_reg) : int'(s_imm);
        if (!from_reg && s_imm == 0) begin
            if (kind == 2'b01 || kind == 2'b10) n = 32;
            if (kind == 2'b11) return {op[0], cin, op[31:1]};
        end
        for (int i = 0; i < n; i++) begin
            case (kind)
                2'b00: begin c = v[31]; v = {v[30:0], 1'b0}; end
                2'b01: begin c = v[0];  v = {1'b0, v[31:1]}; end
                2'b10: begin c = v[0];  v = {v[31], v[31:1]}; end
                default: begin c = v[0]; v = {v[0], v[31:1]}; end
            endcase
        end
        return {c, v};
    endfunction

    function automatic string tag_of(input logic [1:0] kind, input logic from_reg,
                                     input logic [4:0] s_imm, input logic [7:0] s_reg,
                                     input logic imm_sel);
        if (imm_sel) return "R9";
        if (from_reg) begin
            if (s_reg == 0) return "R5";
            if (kind == 2'b11) return "R8";
            if (s_reg >= 32 && kind == 2'b10) return "R7";
            if (s_reg >= 32) return "R6";
            return "R1";
        end
        if (s_imm != 0) return "R1";
        if (kind == 2'b00) return "R2";
        if (kind == 2'b11) return "R4";
        return "R3";
    endfunction

    task automatic apply(input logic [31:0] op, input logic [1:0] kind, input logic from_reg,
                         input logic [4:0] s_imm, input logic [7:0] s_reg, input logic imm_sel,
                         input logic [7:0] iv, input logic [3:0] ir, input logic cin,
                         input string tag);
        logic [32:0] exp;
        @(negedge clk);
        op_value = op; shift_kind = kind; amount_from_reg = from_reg;
        shamt_imm = s_imm; shamt_reg = s_reg; use_imm = imm_sel;
        imm_value = iv; imm_rot = ir; carry_in = cin;
        #1;
        exp = ref_model(op, kind, from_reg, s_imm, s_reg, imm_sel, iv, ir, cin);
        tests++;
        if ({carry_out, result} !== exp) begin
            fails++;
            $display("FAIL %s: actual carry=%0b result=%08h expected carry=%0b result=%08h",
                     tag, carry_out, result, exp[32], exp[31:0]);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rop;
        logic [1:0]  rk;
        logic        rfr, rim, rc;
        logic [4:0]  rsi;
        logic [7:0]  rsr, riv;
        logic [3:0]  rir;
        void'($urandom(32'h5eed_1234));
        op_value = '0; shift_kind = '0; amount_from_reg = 0; shamt_imm = '0;
        shamt_reg = '0; use_imm = 0; imm_value = '0; imm_rot = '0; carry_in = 0;
        // Idle inputs: zero operand passes through (R2)
        apply(32'h0, 2'b00, 0, 5'd0, 8'd0, 0, 8'd0, 4'd0, 1'b0, "R2");
        // R1 basic shifts
        apply(32'h8000_0001, 2'b00, 0, 5'd1, 8'd0, 0, 8'd0, 4'd0, 1'b0, "R1");
        apply(32'h8000_0001, 2'b01, 0, 5'd1, 8'd0, 0, 8'd0, 4'd0, 1'b0, "R1");
        apply(32'h8000_0000, 2'b10, 1, 5'd0, 8'd31, 0, 8'd0, 4'd0, 1'b0, "R1");
        apply(32'h1234_5678, 2'b11, 0, 5'd4, 8'd0, 0, 8'd0, 4'd0, 1'b0, "R1");
        // R2 LSL #0 keeps carry
        apply(32'hdead_beef, 2'b00, 0, 5'd0, 8'd0, 0, 8'd0, 4'd0, 1'b1, "R2");
        // R3 LSR/ASR #0 as 32
        apply(32'h8000_0000, 2'b01, 0, 5'd0, 8'd0, 0, 8'd0, 4'd0, 1'b0, "R3");
        apply(32'h8000_0000, 2'b10, 0, 5'd0, 8'd0, 0, 8'd0, 4'd0, 1'b0, "R3");
        apply(32'h7fff_ffff, 2'b10, 0, 5'd0, 8'd0, 0, 8'd0, 4'd0, 1'b1, "R3");
        // R4 rotate through carry
        apply(32'h0000_0003, 2'b11, 0, 5'd0, 8'd0, 0, 8'd0, 4'd0, 1'b1, "R4");
        apply(32'h0000_0002, 2'b11, 0, 5'd0, 8'd0, 0, 8'd0, 4'd0, 1'b0, "R4");
        // R5 register amount zero
        for (int k = 0; k < 4; k++)
            apply(32'hf0f0_1234, 2'(k), 1, 5'd7, 8'd0, 0, 8'd0, 4'd0, 1'b1, "R5");
        // R6 logical by 32 / above
        apply(32'h0000_0001, 2'b00, 1, 5'd0, 8'd32, 0, 8'd0, 4'd0, 1'b0, "R6");
        apply(32'h8000_0000, 2'b01, 1, 5'd0, 8'd32, 0, 8'd0, 4'd0, 1'b0, "R6");
        apply(32'hffff_ffff, 2'b00, 1, 5'd0, 8'd33, 0, 8'd0, 4'd0, 1'b1, "R6");
        apply(32'hffff_ffff, 2'b01, 1, 5'd0, 8'd255, 0, 8'd0, 4'd0, 1'b1, "R6");
        // R7 arithmetic right large
        apply(32'h8000_0000, 2'b10, 1, 5'd0, 8'd200, 0, 8'd0, 4'd0, 1'b0, "R7");
        apply(32'h4000_0000, 2'b10, 1, 5'd0, 8'd32, 0, 8'd0, 4'd0, 1'b1, "R7");
        // R8 register rotate
        apply(32'h8000_0001, 2'b11, 1, 5'd0, 8'd32, 0, 8'd0, 4'd0, 1'b0, "R8");
        apply(32'h0000_0001, 2'b11, 1, 5'd0, 8'd64, 0, 8'd0, 4'd0, 1'b1, "R8");
        apply(32'h0000_0001, 2'b11, 1, 5'd0, 8'd33, 0, 8'd0, 4'd0, 1'b0, "R8");
        // R9 immediate, other fields ignored
        apply(32'hffff_ffff, 2'b10, 1, 5'd9, 8'd40, 1, 8'hff, 4'd4, 1'b0, "R9");
        apply(32'h1234_5678, 2'b11, 0, 5'd0, 8'd0, 1, 8'h81, 4'd1, 1'b0, "R9");
        // R10 immediate carry
        apply(32'h0, 2'b00, 0, 5'd0, 8'd0, 1, 8'h80, 4'd0, 1'b1, "R10");
        apply(32'h0, 2'b00, 0, 5'd0, 8'd0, 1, 8'h01, 4'd1, 1'b0, "R10");
        apply(32'h0, 2'b00, 0, 5'd0, 8'd0, 1, 8'h02, 4'd1, 1'b1, "R10");
        for (int r = 0; r < 16; r++)
            apply(32'h0, 2'b00, 0, 5'd0, 8'd0, 1, 8'hc3, 4'(r), 1'b1, "R10");
        // Constrained random
        for (int i = 0; i < 4000; i++) begin
            rop = $urandom;
            rk  = 2'($urandom);
            rfr = 1'($urandom);
            rsi = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
            rsr = ($urandom % 2 == 0) ? 8'($urandom % 70) : 8'($urandom);
            rim = ($urandom % 5 == 0);
            riv = 8'($urandom);
            rir = 4'($urandom);
            rc  = 1'($urandom);
            apply(rop, rk, rfr, rsi, rsr, rim, riv, rir, rc, tag_of(rk, rfr, rsi, rsr, rim));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule